// File: doc/BRIEF.md
# First-Order Delta-Sigma Bitstream Modulator

This block converts a stream of signed multi-bit samples, already interpolated upstream to the oversampled rate, into a one-bit pulse-density stream. That stream drives a single-bit output stage. One error-feedback integrator accumulates the difference between the held sample and the fed-back one-bit decision. The quantizer takes the sign of that integrator. The signal therefore passes through unchanged, while the quantization error is first-differenced and pushed toward high frequencies.

A new sample is captured whenever the valid strobe is high, and it is held until the next strobe. The loop advances once per clock on which the oversampled-rate enable is high. A synchronous reset returns the loop to a known state. Over a long run with a constant sample, the fraction of ones in the output follows the sample value.

Top module: `sdm_bitstream_mod`

## Requirements
- R1: While `rst` is high at a clock edge, the held sample and the integrator are cleared to 0 and `bit_out` becomes 0. `bit_out` stays 0 until the first clock edge with `ce` high.
- R2: On a clock edge with `ce` low and `rst` low, `bit_out` and the integrator do not change.
- R3: On a clock edge with `din_valid` high, `din` (16-bit two's complement) is captured as the held sample. The loop uses it from the next enabled edge onward. `din` is ignored while `din_valid` is low.
- R4: On each enabled edge the integrator becomes acc + s − f. Here s is the held sample, and f is +32768 when `bit_out` is 1 and −32768 when it is 0. Then `bit_out` becomes 1 exactly when the new integrator value is non-negative.
- R5: For every 16-bit sample the 18-bit integrator stays within [−65536, +65536] and never reaches its saturation limits.
- R6: Starting from reset with a constant held sample s, the number of ones in `bit_out` over the first 65536 enabled edges is 32768 + s, within ±2.
- R7: The first enabled edge after reset drives `bit_out` to 1 for any held sample.
- R8: With the held sample at −32768 after reset, `bit_out` is 1 for exactly the first enabled edge and 0 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Oversampled-rate step enable |
| din_valid | input | 1 | Captures `din` as the held sample |
| din | input | 16 | Signed sample, two's complement |
| bit_out | output | 1 | Pulse-density output bit |

## Verification
Several properties are checked on every cycle by assertions:
- the direction of each integrator step follows the current output bit;
- the integrator stays inside its bound and never saturates;
- the output bit equals the sign of the freshly updated integrator;
- the held sample and the loop state are frozen on edges where they must not move.

Other behaviour can only be shown by the bench's scenarios. These are the exact bit-by-bit sequence under mixed enable and strobe patterns, the long-run ones count for chosen constant samples, and the start-up behaviour after reset at the negative extreme.

// File: rtl/sdm_pkg.sv
`timescale 1ns/1ps
package sdm_pkg;
  localparam int unsigned SDM_DATA_W = 16;
  localparam int unsigned SDM_GUARD_W = 2;
endpackage

// File: rtl/sdm_hold.sv
`timescale 1ns/1ps
module sdm_hold #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] smp
);
  always_ff @(posedge clk) begin
    if (rst)      smp <= '0;
    else if (vld) smp <= din;
  end

  // R3: without a strobe the held sample does not move
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!vld && !rst) |=> $stable(smp));
endmodule

// File: rtl/sdm_integ.sv
`timescale 1ns/1ps
module sdm_integ #(
  parameter int DW = 16,
  parameter int AW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic signed [DW-1:0] smp,
  input  logic                 fb_bit,
  output logic signed [AW-1:0] acc,
  output logic signed [AW-1:0] acc_nxt,
  output logic                 sat_hit
);
  localparam int FS = 1 << (DW-1);
  localparam logic signed [AW:0]   FSW  = (AW+1)'(FS);
  localparam logic signed [AW-1:0] LIM  = AW'(2*FS);
  localparam logic signed [AW-1:0] AMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] AMIN = {1'b1, {(AW-1){1'b0}}};

  // One unsaturated loop step, one bit wider than the integrator
  function automatic logic signed [AW:0] raw_step(
    input logic signed [AW-1:0] a,
    input logic signed [DW-1:0] x,
    input logic                 y);
    logic signed [AW:0] f;
    logic signed [AW:0] xe;
    logic signed [AW:0] ae;
    f  = y ? FSW : -FSW;
    xe = $signed({{(AW+1-DW){x[DW-1]}}, x});
    ae = $signed({a[AW-1], a});
    return ae + xe - f;
  endfunction

  function automatic logic signed [AW-1:0] clamp(input logic signed [AW:0] v);
    if (v[AW] != v[AW-1]) return v[AW] ? AMIN : AMAX;
    return v[AW-1:0];
  endfunction

  logic signed [AW:0] sum_w;

  always_comb begin
    sum_w   = raw_step(acc, smp, fb_bit);
    sat_hit = sum_w[AW] ^ sum_w[AW-1];
    acc_nxt = clamp(sum_w);
  end

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (ce) acc <= acc_nxt;
  end

  // R4: a one on the output never lets the integrator rise
  p_fb_down_r4: assert property (@(posedge clk) disable iff (rst)
    (ce && fb_bit && !rst) |=> ($signed(acc) <= $signed($past(acc))));
  // R4: a zero on the output never lets the integrator fall
  p_fb_up_r4: assert property (@(posedge clk) disable iff (rst)
    (ce && !fb_bit && !rst) |=> ($signed(acc) >= $signed($past(acc))));
  // R2: a step without enable leaves the state alone
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!ce && !rst) |=> $stable(acc));
  // R5: the loop state stays bounded
  p_bound_r5: assert property (@(posedge clk) disable iff (rst)
    ($signed(acc) <= LIM) && ($signed(acc) >= -LIM));
  // R5: the clamp is never needed
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    ce |-> !sat_hit);
endmodule

// File: rtl/sdm_quant.sv
`timescale 1ns/1ps
module sdm_quant #(
  parameter int AW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic signed [AW-1:0] acc_nxt,
  input  logic signed [AW-1:0] acc_now,
  output logic                 bit_q
);
  always_ff @(posedge clk) begin
    if (rst)     bit_q <= 1'b0;
    else if (ce) bit_q <= ~acc_nxt[AW-1];
  end

  // R4: after a step the output equals the sign decision of the stored integrator
  p_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (ce && !rst) |=> (bit_q == ~acc_now[AW-1]));
endmodule

// File: rtl/sdm_bitstream_mod.sv
`timescale 1ns/1ps
module sdm_bitstream_mod
  import sdm_pkg::*;
#(
  parameter int DW    = SDM_DATA_W,
  parameter int GUARD = SDM_GUARD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          din_valid,
  input  logic [DW-1:0] din,
  output logic          bit_out
);
  localparam int AW = DW + GUARD;

  logic signed [DW-1:0] w_smp;
  logic signed [AW-1:0] w_acc;
  logic signed [AW-1:0] w_acc_nxt;
  logic                 w_sat;
  logic                 w_bit;

  sdm_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .vld(din_valid), .din($signed(din)), .smp(w_smp)
  );

  sdm_integ #(.DW(DW), .AW(AW)) u_integ (
    .clk(clk), .rst(rst), .ce(ce), .smp(w_smp), .fb_bit(w_bit),
    .acc(w_acc), .acc_nxt(w_acc_nxt), .sat_hit(w_sat)
  );

  sdm_quant #(.AW(AW)) u_quant (
    .clk(clk), .rst(rst), .ce(ce), .acc_nxt(w_acc_nxt), .acc_now(w_acc),
    .bit_q(w_bit)
  );

  assign bit_out = w_bit;

  // R1: reset forces a zero output
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (bit_out == 1'b0));
  // R2: no enable, no output change
  p_hold_out_r2: assert property (@(posedge clk) disable iff (rst)
    (!ce && !rst) |=> $stable(bit_out));
endmodule

// File: tb/sdm_bitstream_mod_tb.sv
`timescale 1ns/1ps
module sdm_bitstream_mod_tb;
  localparam int FS = 32768;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic        din_valid = 1'b0;
  logic [15:0] din = '0;
  logic        bit_out;

  int n_vec = 0;
  int n_bad = 0;
  int ones  = 0;
  int m_acc = 0;
  int m_out = 0;
  int m_hold = 0;

  bit    q_exp[$];
  string q_tag[$];
  bit    q_cnt[$];

  always #5 clk = ~clk;

  sdm_bitstream_mod u_dut (
    .clk(clk), .rst(rst), .ce(ce), .din_valid(din_valid), .din(din),
    .bit_out(bit_out)
  );

  // Driver: applies one cycle of stimulus and queues the expected output bit
  task automatic drive(input logic r, input logic c, input logic v,
                       input logic [15:0] d, input string tag, input bit cnt);
    @(negedge clk);
    rst = r; ce = c; din_valid = v; din = d;
    if (r) begin
      m_acc = 0; m_out = 0; m_hold = 0;
    end else begin
      if (c) begin
        if (m_out == 1) m_acc = m_acc + m_hold - FS;
        else            m_acc = m_acc + m_hold + FS;
        m_out = (m_acc < 0) ? 0 : 1;
      end
      if (v) m_hold = int'($signed(d));
    end
    q_exp.push_back(m_out == 1);
    q_tag.push_back(tag);
    q_cnt.push_back(cnt);
  endtask

  // Monitor: compares each queued item after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() != 0) begin
        bit    e;
        string t;
        bit    k;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        k = q_cnt.pop_front();
        n_vec++;
        if (bit_out !== e) begin
          n_bad++;
          $display("FAIL %s: bit_out=%0b expected %0b", t, bit_out, e);
        end
        if (k && bit_out === 1'b1) ones++;
      end
    end
  end

  task automatic settle();
    @(posedge clk);
    #3;
  endtask

  task automatic reset_and_load(input logic [15:0] s);
    drive(1, 0, 0, 16'h5A5A, "R1", 0);
    drive(1, 1, 1, 16'h1234, "R1", 0);
    drive(0, 0, 1, s, "R1", 0);
  endtask

  task automatic density(input int s, input string tag);
    reset_and_load(16'(s));
    settle();
    ones = 0;
    for (int i = 0; i < 65536; i++)
      drive(0, 1, 0, 16'(i * 40503 + 7), "R4", 1);
    settle();
    n_vec++;
    if (ones < FS + s - 2 || ones > FS + s + 2) begin
      n_bad++;
      $display("FAIL %s: ones=%0d expected %0d +/-2", tag, ones, FS + s);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state, strobe and enable asserted during reset are overridden
    reset_and_load(16'd1000);
    // R2 enable low: output must stay at 0; R3 garbage without strobe ignored
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 16'hFFFF, "R2", 0);
    // R7 first enabled edge gives a one
    drive(0, 1, 0, 16'h8000, "R7", 0);
    // R4 / R3 mixed enable and strobe pattern
    for (int i = 0; i < 60; i++)
      drive(0, (i % 3) != 0, (i % 11) == 5, 16'(i * 997 - 20000), "R3", 0);
    // R2 long idle stretch after activity
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 16'(i * 31), "R2", 0);
    // R7 with a negative sample
    reset_and_load(16'(-12000));
    drive(0, 1, 0, 16'h0000, "R7", 0);
    for (int i = 0; i < 20; i++) drive(0, 1, 0, 16'h7FFF, "R4", 0);
    // R6 ones density for two constant samples
    density(12345, "R6");
    density(-20000, "R6");
    // R8 negative extreme
    reset_and_load(16'h8000);
    settle();
    ones = 0;
    for (int i = 0; i < 64; i++) drive(0, 1, 0, 16'(i * 77), "R8", 1);
    settle();
    n_vec++;
    if (ones != 1) begin
      n_bad++;
      $display("FAIL R8: ones=%0d expected 1", ones);
    end
    // R5 positive extreme keeps tracking the bit-exact model
    reset_and_load(16'h7FFF);
    for (int i = 0; i < 40; i++) drive(0, 1, 0, 16'h0000, "R5", 0);
    settle();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule